// File: doc/BRIEF.md
# Tagged Floating-Point Register Stack

This block holds eight 80-bit extended-precision registers that are arranged as a stack. A 3-bit top pointer names the physical register that is the current top. Operands are reached in two ways: by push and pop at the top, or by reading or writing entry ST(i). Entry ST(i) is the physical register (top + i) mod 8. Each register carries a 2-bit tag that the block derives from the value written into it. The tags show which entries are empty, and the block uses them to detect stack overflow and stack underflow. The whole tag word can be read at any time and can be replaced in one command, which is how the environment is saved and restored.

Commands arrive on a valid/ready port. A command is accepted on a rising clock edge where `cmd_valid` and `cmd_ready` are both high. Every effect of that command is visible from the next cycle onward: the top pointer, the tag word, the fault pulses and any read response. Read results leave on a valid/ready response port. While a response is pending and `rsp_ready` is low, `cmd_ready` is low and the response is held unchanged. This back-pressure stalls every kind of command, not just reads. With `rsp_ready` high, the command port accepts one command per cycle.

Top module: `fp_tag_stack`

## Requirements
- R1: After reset, `top_ptr` is 0, `tag_word` is 16'hFFFF (every entry empty), `rsp_valid` is low and all three fault outputs are low.
- R2: An accepted push (`cmd_op`=0) onto an empty slot decrements `top_ptr` mod 8 and stores `cmd_data` in the new top register, together with its derived tag.
- R3: The written tag is 2'b10 when the exponent (bits 78:64) is all ones, 2'b01 when the exponent and the significand (bits 63:0) are both zero, 2'b10 when the exponent is zero and the significand is nonzero, and 2'b00 otherwise. 2'b11 means empty.
- R4: An accepted pop (`cmd_op`=1) of a non-empty top sets that entry's tag to 2'b11 and increments `top_ptr` mod 8.
- R5: An accepted read (`cmd_op`=3) of a non-empty ST(`cmd_idx`) raises `rsp_valid` the next cycle. The response carries the data and tag of physical register (`top_ptr` + `cmd_idx`) mod 8.
- R6: An accepted write (`cmd_op`=2) replaces the value and tag of ST(`cmd_idx`) whatever its previous tag was, and leaves `top_ptr` unchanged.
- R7: A push whose target slot is not empty raises `fault_overflow` and `fault_invalid` for one cycle. The registers, the tags and `top_ptr` stay unchanged.
- R8: A pop or read of an empty slot raises `fault_underflow` and `fault_invalid` for one cycle, produces no response, and leaves the registers, the tags and `top_ptr` unchanged.
- R9: A tag load (`cmd_op`=4) replaces the whole `tag_word` with `cmd_tags`. Physical register k sits in bits 2k+1:2k. The register data and `top_ptr` are not affected.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `cmd_ready` is low and `rsp_data` and `rsp_tag` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_op | input | 3 | 0 push, 1 pop, 2 write, 3 read, 4 tag load |
| cmd_idx | input | 3 | Stack-relative index i for read and write |
| cmd_data | input | 80 | Value for push and write |
| cmd_tags | input | 16 | New tag word for tag load |
| rsp_valid | output | 1 | Read response available |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 80 | Read value |
| rsp_tag | output | 2 | Tag of the read entry |
| top_ptr | output | 3 | Physical index of the current top |
| tag_word | output | 16 | All tags, register 0 in bits 1:0 |
| fault_overflow | output | 1 | One-cycle pulse: push onto an occupied slot |
| fault_underflow | output | 1 | One-cycle pulse: pop or read of an empty slot |
| fault_invalid | output | 1 | One-cycle pulse with either stack fault |

## Verification
The assertions assume that `cmd_op` only takes the codes 0 to 4 while `cmd_valid` is high. They also assume that `rsp_ready` is not withdrawn in a way that makes the consumer expect a changed response. The stimulus picks opcodes only from the five defined codes. It holds `rsp_ready` high except in one directed stall window, and inside that window it offers no new command until the response has been taken. The random values are drawn so that every tag class, including denormal-style and all-ones exponents, appears often. Operations are mixed so that the stack fills up, wraps past slot 0 and empties again, which drives the overflow and underflow paths.

// File: rtl/fp_tag_stack_pkg.sv
package fp_tag_stack_pkg;
  localparam int EXP_W  = 15;
  localparam int SIG_W  = 64;
  localparam int WORD_W = 1 + EXP_W + SIG_W;

  typedef enum logic [1:0] {
    TAG_VALID   = 2'b00,
    TAG_ZERO    = 2'b01,
    TAG_SPECIAL = 2'b10,
    TAG_EMPTY   = 2'b11
  } tag_e;

  typedef enum logic [2:0] {
    OP_PUSH  = 3'd0,
    OP_POP   = 3'd1,
    OP_WRITE = 3'd2,
    OP_READ  = 3'd3,
    OP_LDTAG = 3'd4
  } op_e;
endpackage

// File: rtl/fts_classify.sv
module fts_classify
  import fp_tag_stack_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int SW = SIG_W
) (
  input  logic [EW+SW-1:0] value,
  output logic [1:0]       tag
);
  logic [EW-1:0] expo;
  logic [SW-1:0] sig;
  logic          exp_ones, exp_zero, sig_zero;

  assign expo     = value[EW+SW-1:SW];
  assign sig      = value[SW-1:0];
  assign exp_ones = &expo;
  assign exp_zero = ~|expo;
  assign sig_zero = ~|sig;

  // R3: classification of an incoming value
  always_comb begin
    if (exp_ones)                  tag = TAG_SPECIAL;
    else if (exp_zero && sig_zero) tag = TAG_ZERO;
    else if (exp_zero)             tag = TAG_SPECIAL;
    else                           tag = TAG_VALID;
  end
endmodule

// File: rtl/fts_regfile.sv
module fts_regfile
  import fp_tag_stack_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WW    = WORD_W,
  localparam int IW   = $clog2(DEPTH),
  localparam int TW   = 2 * DEPTH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_slot,
  input  logic [WW-1:0] wr_data,
  input  logic [1:0]    wr_tag,
  input  logic          clr_en,
  input  logic [IW-1:0] clr_slot,
  input  logic          ld_en,
  input  logic [TW-1:0] ld_tags,
  input  logic [IW-1:0] rd_slot,
  output logic [WW-1:0] rd_data,
  output logic [1:0]    rd_tag,
  output logic [TW-1:0] tags_out
);
  logic [DEPTH-1:0][WW-1:0] regs;
  logic [DEPTH-1:0][1:0]    tags;
  logic [DEPTH-1:0]         we, ce;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_ent
      assign we[g] = wr_en  && (wr_slot  == IW'(g));
      assign ce[g] = clr_en && (clr_slot == IW'(g));

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          regs[g] <= '0;
          tags[g] <= TAG_EMPTY;
        end else begin
          if (we[g]) regs[g] <= wr_data;
          if (ld_en)      tags[g] <= ld_tags[2*g +: 2];
          else if (we[g]) tags[g] <= wr_tag;
          else if (ce[g]) tags[g] <= TAG_EMPTY;
        end
      end
    end
  endgenerate

  assign rd_data  = regs[rd_slot];
  assign rd_tag   = tags[rd_slot];
  assign tags_out = tags;
endmodule

// File: rtl/fts_ctrl.sv
module fts_ctrl
  import fp_tag_stack_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [2:0]    op,
  input  logic [IW-1:0] idx,
  input  logic [1:0]    sel_tag,
  output logic [IW-1:0] sel_slot,
  output logic          wr_en,
  output logic          clr_en,
  output logic          ld_en,
  output logic          rd_en,
  output logic [IW-1:0] top,
  output logic          ovf_q,
  output logic          unf_q,
  output logic          inv_q
);
  logic ovf, unf;
  logic sel_empty;

  assign sel_empty = (sel_tag == TAG_EMPTY);

  always_comb begin
    sel_slot = top;
    ovf      = 1'b0;
    unf      = 1'b0;
    wr_en    = 1'b0;
    clr_en   = 1'b0;
    ld_en    = 1'b0;
    rd_en    = 1'b0;
    case (op)
      OP_PUSH: begin
        sel_slot = top - IW'(1);
        ovf      = fire && !sel_empty;       // R7
        wr_en    = fire && sel_empty;        // R2
      end
      OP_POP: begin
        unf      = fire && sel_empty;        // R8
        clr_en   = fire && !sel_empty;       // R4
      end
      OP_WRITE: begin
        sel_slot = top + idx;
        wr_en    = fire;                     // R6
      end
      OP_READ: begin
        sel_slot = top + idx;
        unf      = fire && sel_empty;        // R8
        rd_en    = fire && !sel_empty;       // R5
      end
      OP_LDTAG: ld_en = fire;                // R9
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      top   <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
      inv_q <= 1'b0;
    end else begin
      if (wr_en && op == OP_PUSH) top <= top - IW'(1);
      else if (clr_en)            top <= top + IW'(1);
      ovf_q <= ovf;
      unf_q <= unf;
      inv_q <= ovf || unf;
    end
  end
endmodule

// File: rtl/fts_rsp.sv
module fts_rsp
  import fp_tag_stack_pkg::*;
#(
  parameter int WW = WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [WW-1:0] data_in,
  input  logic [1:0]    tag_in,
  input  logic          rsp_ready,
  output logic          rsp_valid,
  output logic [WW-1:0] rsp_data,
  output logic [1:0]    rsp_tag,
  output logic          take_ok
);
  // R10: a held response blocks new commands
  assign take_ok = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_tag   <= TAG_EMPTY;
    end else if (load) begin
      rsp_valid <= 1'b1;
      rsp_data  <= data_in;
      rsp_tag   <= tag_in;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/fp_tag_stack.sv
module fp_tag_stack
  import fp_tag_stack_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IW   = $clog2(DEPTH),
  localparam int TW   = 2 * DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [IW-1:0]     cmd_idx,
  input  logic [WORD_W-1:0] cmd_data,
  input  logic [TW-1:0]     cmd_tags,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_data,
  output logic [1:0]        rsp_tag,
  output logic [IW-1:0]     top_ptr,
  output logic [TW-1:0]     tag_word,
  output logic              fault_overflow,
  output logic              fault_underflow,
  output logic              fault_invalid
);
  logic              fire;
  logic [IW-1:0]     sel_slot;
  logic [1:0]        sel_tag, new_tag;
  logic [WORD_W-1:0] sel_data;
  logic              wr_en, clr_en, ld_en, rd_en;

  assign fire = cmd_valid && cmd_ready;

  fts_classify #(.EW(EXP_W), .SW(SIG_W)) u_cls (
    .value (cmd_data[EXP_W+SIG_W-1:0]),
    .tag   (new_tag)
  );

  fts_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .op       (cmd_op),
    .idx      (cmd_idx),
    .sel_tag  (sel_tag),
    .sel_slot (sel_slot),
    .wr_en    (wr_en),
    .clr_en   (clr_en),
    .ld_en    (ld_en),
    .rd_en    (rd_en),
    .top      (top_ptr),
    .ovf_q    (fault_overflow),
    .unf_q    (fault_underflow),
    .inv_q    (fault_invalid)
  );

  fts_regfile #(.DEPTH(DEPTH), .WW(WORD_W)) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_slot  (sel_slot),
    .wr_data  (cmd_data),
    .wr_tag   (new_tag),
    .clr_en   (clr_en),
    .clr_slot (sel_slot),
    .ld_en    (ld_en),
    .ld_tags  (cmd_tags),
    .rd_slot  (sel_slot),
    .rd_data  (sel_data),
    .rd_tag   (sel_tag),
    .tags_out (tag_word)
  );

  fts_rsp #(.WW(WORD_W)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (rd_en),
    .data_in   (sel_data),
    .tag_in    (sel_tag),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_tag   (rsp_tag),
    .take_ok   (cmd_ready)
  );
endmodule

// File: rtl/fts_checker.sv
module fts_checker
  import fp_tag_stack_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IW   = $clog2(DEPTH),
  localparam int TW   = 2 * DEPTH
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [2:0]        cmd_op,
  input logic [TW-1:0]     cmd_tags,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [WORD_W-1:0] rsp_data,
  input logic [1:0]        rsp_tag,
  input logic [IW-1:0]     top_ptr,
  input logic [TW-1:0]     tag_word,
  input logic              fault_overflow,
  input logic              fault_underflow,
  input logic              fault_invalid
);
  logic fire;
  assign fire = cmd_valid && cmd_ready;

  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cmd_op == OP_PUSH) |=> (fault_overflow || top_ptr == $past(top_ptr) - IW'(1))); // R2
  AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cmd_op == OP_POP) |=> (fault_underflow || top_ptr == $past(top_ptr) + IW'(1))); // R4
  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fault_overflow |-> (top_ptr == $past(top_ptr) && tag_word == $past(tag_word))); // R7
  AST_UNF_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_overflow || fault_underflow) |-> fault_invalid); // R8
  AST_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(fault_overflow && fault_underflow)); // R8
  AST_TAG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cmd_op == OP_LDTAG) |=> (tag_word == $past(cmd_tags))); // R9
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_tag))); // R10
  AST_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !cmd_ready); // R10
endmodule

bind fp_tag_stack fts_checker #(.DEPTH(DEPTH)) u_fts_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cmd_valid       (cmd_valid),
  .cmd_ready       (cmd_ready),
  .cmd_op          (cmd_op),
  .cmd_tags        (cmd_tags),
  .rsp_valid       (rsp_valid),
  .rsp_ready       (rsp_ready),
  .rsp_data        (rsp_data),
  .rsp_tag         (rsp_tag),
  .top_ptr         (top_ptr),
  .tag_word        (tag_word),
  .fault_overflow  (fault_overflow),
  .fault_underflow (fault_underflow),
  .fault_invalid   (fault_invalid)
);

// File: tb/fp_tag_stack_test.sv
module fp_tag_stack_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic [2:0]  cmd_idx = '0;
  logic [79:0] cmd_data = '0;
  logic [15:0] cmd_tags = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [79:0] rsp_data;
  logic [1:0]  rsp_tag;
  logic [2:0]  top_ptr;
  logic [15:0] tag_word;
  logic        fault_overflow, fault_underflow, fault_invalid;

  int checks = 0;
  int errors = 0;

  logic [79:0] m_regs [8];
  logic [1:0]  m_tags [8];
  logic [2:0]  m_top;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_tag_stack uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_idx(cmd_idx), .cmd_data(cmd_data), .cmd_tags(cmd_tags),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_tag(rsp_tag),
    .top_ptr(top_ptr), .tag_word(tag_word), .fault_overflow(fault_overflow),
    .fault_underflow(fault_underflow), .fault_invalid(fault_invalid)
  );

  function automatic logic [1:0] ref_tag(logic [79:0] v);
    if (&v[78:64]) return 2'b10;
    if (v[78:64] == 15'd0 && v[63:0] == 64'd0) return 2'b01;
    if (v[78:64] == 15'd0) return 2'b10;
    return 2'b00;
  endfunction

  function automatic logic [15:0] ref_word();
    logic [15:0] w;
    for (int k = 0; k < 8; k++) w[2*k +: 2] = m_tags[k];
    return w;
  endfunction

  function automatic logic [79:0] rand_val();
    logic [79:0] v;
    v[79]    = 1'($urandom);
    v[63:0]  = {$urandom, $urandom};
    case ($urandom % 5)
      0: v[78:0] = '0;
      1: v[78:64] = 15'h7FFF;
      2: v[78:64] = 15'h0;
      default: v[78:64] = 15'(($urandom % 32766) + 1);
    endcase
    return v;
  endfunction

  task automatic chk(string req, logic [79:0] act, logic [79:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Issue one command with model update and output checks; rsp_ready assumed high.
  task automatic issue(logic [2:0] op, logic [2:0] idx, logic [79:0] d, logic [15:0] t, string req);
    logic [2:0] slot;
    logic e_ovf, e_unf, e_rsp;
    logic [79:0] e_data;
    logic [1:0]  e_tag;
    e_ovf = 0; e_unf = 0; e_rsp = 0; e_data = '0; e_tag = '0;
    case (op)
      3'd0: begin
        slot = m_top - 3'd1;
        if (m_tags[slot] != 2'b11) e_ovf = 1;
        else begin m_top = slot; m_regs[slot] = d; m_tags[slot] = ref_tag(d); end
      end
      3'd1: begin
        slot = m_top;
        if (m_tags[slot] == 2'b11) e_unf = 1;
        else begin m_tags[slot] = 2'b11; m_top = m_top + 3'd1; end
      end
      3'd2: begin
        slot = m_top + idx;
        m_regs[slot] = d; m_tags[slot] = ref_tag(d);
      end
      3'd3: begin
        slot = m_top + idx;
        if (m_tags[slot] == 2'b11) e_unf = 1;
        else begin e_rsp = 1; e_data = m_regs[slot]; e_tag = m_tags[slot]; end
      end
      default: for (int k = 0; k < 8; k++) m_tags[k] = t[2*k +: 2];
    endcase
    cmd_op = op; cmd_idx = idx; cmd_data = d; cmd_tags = t; cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(req, 80'(top_ptr), 80'(m_top), "top_ptr");
    chk(req, 80'(tag_word), 80'(ref_word()), "tag_word");
    chk(e_ovf ? "R7" : req, 80'(fault_overflow), 80'(e_ovf), "fault_overflow");
    chk(e_unf ? "R8" : req, 80'(fault_underflow), 80'(e_unf), "fault_underflow");
    chk((e_ovf || e_unf) ? "R8" : req, 80'(fault_invalid), 80'(e_ovf || e_unf), "fault_invalid");
    chk(e_unf ? "R8" : "R5", 80'(rsp_valid), 80'(e_rsp), "rsp_valid");
    if (e_rsp) begin
      chk("R5", rsp_data, e_data, "rsp_data");
      chk("R3", 80'(rsp_tag), 80'(e_tag), "rsp_tag");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
  end

  initial begin
    logic [79:0] held;
    void'($urandom(32'h5EED_0042));
    for (int k = 0; k < 8; k++) begin m_regs[k] = '0; m_tags[k] = 2'b11; end
    m_top = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", 80'(top_ptr), 80'd0, "top_ptr");
    chk("R1", 80'(tag_word), 80'hFFFF, "tag_word");
    chk("R1", 80'(rsp_valid), 80'd0, "rsp_valid");
    chk("R1", 80'({fault_overflow, fault_underflow, fault_invalid}), 80'd0, "faults");

    // R8 underflow on an empty stack
    issue(3'd1, 3'd0, '0, '0, "R8");
    issue(3'd3, 3'd5, '0, '0, "R8");
    // R3 one value of each class, then fill the stack (R2)
    issue(3'd0, 3'd0, 80'h0, '0, "R3");
    issue(3'd0, 3'd0, {1'b1, 15'h7FFF, 64'h0}, '0, "R3");
    issue(3'd0, 3'd0, {1'b0, 15'h0000, 64'h1}, '0, "R3");
    issue(3'd0, 3'd0, {1'b0, 15'h3FFF, 64'h8000_0000_0000_0000}, '0, "R3");
    for (int k = 0; k < 4; k++) issue(3'd0, 3'd0, rand_val(), '0, "R2");
    // R7 ninth push overflows
    issue(3'd0, 3'd0, rand_val(), '0, "R7");
    for (int k = 0; k < 8; k++) issue(3'd3, 3'(k), '0, '0, "R5");
    issue(3'd2, 3'd3, {1'b0, 15'h0, 64'h0}, '0, "R6");
    issue(3'd3, 3'd3, '0, '0, "R6");
    for (int k = 0; k < 8; k++) issue(3'd1, 3'd0, '0, '0, "R4");
    issue(3'd1, 3'd0, '0, '0, "R8");
    // R6 write into an empty slot, then R9 tag load
    issue(3'd2, 3'd6, {1'b0, 15'h4000, 64'h1234}, '0, "R6");
    issue(3'd4, 3'd0, '0, 16'h1B4E, "R9");
    issue(3'd3, 3'd6, '0, '0, "R9");
    issue(3'd4, 3'd0, '0, 16'h3FFF, "R9");
    issue(3'd3, 3'd0, '0, '0, "R9");

    // R10 back-pressure
    issue(3'd4, 3'd0, '0, 16'hFFFF, "R9");
    issue(3'd0, 3'd0, {1'b1, 15'h1234, 64'hABCD}, '0, "R2");
    rsp_ready = 1'b0;
    issue(3'd3, 3'd0, '0, '0, "R5");
    held = rsp_data;
    chk("R10", 80'(cmd_ready), 80'd0, "cmd_ready while stalled");
    repeat (3) @(negedge clk);
    chk("R10", 80'(rsp_valid), 80'd1, "rsp_valid held");
    chk("R10", rsp_data, held, "rsp_data held");
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R10", 80'(rsp_valid), 80'd0, "rsp_valid after take");
    chk("R10", 80'(cmd_ready), 80'd1, "cmd_ready after take");

    // Random mix
    for (int n = 0; n < 600; n++) begin
      int r;
      r = int'($urandom % 10);
      if (r < 3)      issue(3'd0, 3'd0, rand_val(), '0, "R2");
      else if (r < 5) issue(3'd1, 3'd0, '0, '0, "R4");
      else if (r < 6) issue(3'd2, 3'($urandom), rand_val(), '0, "R6");
      else if (r < 9) issue(3'd3, 3'($urandom), '0, '0, "R5");
      else            issue(3'd4, 3'd0, '0, 16'($urandom), "R9");
    end
    report();
  end
endmodule